// File: doc/BRIEF.md
# Time-Multiplexed Mandelbrot Context Scheduler

This block computes Mandelbrot escape counts for a group of N pixels. It uses a single controller and a single pipelined compute unit. Each pixel has its own context: a coordinate, a fixed-point working state, a step code and a finished flag. The contexts sit in a ring of registers.

Each cycle, only the context at the front of the ring is handled. It takes one step of its own six-step sequence, and then the ring shifts by one place. A step either sends an operation into the shared compute unit or collects a result from it. Because every context sends its next operation as soon as it reaches the front, up to N operations can be in the compute unit at once, while there is only one copy of the sequencing logic.

The compute unit has three kinds of operation:
- mapping a pixel to a point of the complex plane;
- a burst of up to CHUNK escape-iteration steps;
- a pass-through that returns the final count.

All operations take the same fixed latency, LAT cycles. A small queue holds results that come back before their context returns to the front. A context that reaches the front and finds no result waiting holds the ring until the result arrives.

Top module: `mandel_ctx_sched`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every field of `iters` is 0.
- R2: When idle, a `start` pulse loads the N coordinate pairs, with pixel i taken from bits `[i*CW +: CW]` of `px_x` and `px_y`. `busy` is 1 on the first sampling after that clock edge. A `start` while `busy` is 1 is ignored, and the current job's results are unaffected.
- R3: Each pixel maps to c = ((x - IMG_W/2) * SCALE, (y - IMG_H/2) * SCALE). All values are signed, W bits wide, with FRAC fractional bits. SCALE is given in that same format.
- R4: Every context starts its iteration with z = 0, zsq = 0, n = 0 and not escaped. One update step uses the old values to compute z.im = 2*mul(z.re, z.im) + c.im and z.re = zsq.re - zsq.im + c.re. It then sets zsq.re = mul(z.re, z.re) and zsq.im = mul(z.im, z.im), and increments n. Here mul(a, b) is the full signed product shifted right arithmetically by FRAC and kept to W bits.
- R5: A step marks the context escaped only when zsq.re + zsq.im is strictly greater than 4.0. A sum exactly equal to 4.0 does not escape. No further steps are applied after escape.
- R6: n never exceeds MAX_ITER. A point that never escapes reports exactly MAX_ITER.
- R7: One burst operation advances n by at most CHUNK. The reported count equals the count from applying single steps without limit until escape or the cap.
- R8: Only the front context is stepped, and the ring shifts by one after every step that is not stalled. When the job ends, field i of `iters` (bits `[i*NW +: NW]`) holds the count for input pixel i.
- R9: A finished context is never stepped again. The job ends only when all N contexts are finished, at a point where the ring is back in its loaded order. `busy` then drops and `done` rises, and `iters` holds its value until the next start.
- R10: Results come back in the order their operations were sent. A collecting step with no result waiting stalls the ring. The result queue never holds more than N entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| px_x | input | N*CW | Column coordinate of each pixel |
| px_y | input | N*CW | Row coordinate of each pixel |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job complete; results valid |
| iters | output | N*NW | Escape count of each pixel, NW = clog2(MAX_ITER+1) |

## Verification
The bench builds the block with N=3 contexts and a compute latency of LAT=6, longer than the ring. This forces frequent collect stalls and lets results pile up in the queue, so the ordering and stall rules of R10 are exercised rather than left idle. The 64x64 image with SCALE of 1/16 maps every pixel into [-2, 2). The cap of 32 and burst size of 6 are kept. With these values the corners escape on the first step, the centre reaches the cap, and the point c = -2 lands with zsq sum exactly 4.0, which tests the strict escape comparison.

// File: rtl/mandel_ctx_sched.sv
module mandel_ctx_sched #(
  parameter int N        = 8,
  parameter int LAT      = 4,
  parameter int CW       = 8,
  parameter int W        = 24,
  parameter int FRAC     = 12,
  parameter int IMG_W    = 64,
  parameter int IMG_H    = 64,
  parameter int SCALE    = 256,
  parameter int CHUNK    = 6,
  parameter int MAX_ITER = 32,
  localparam int NW      = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*CW-1:0]   px_x,
  input  logic [N*CW-1:0]   px_y,
  output logic              busy,
  output logic              done,
  output logic [N*NW-1:0]   iters
);
  localparam int PW   = (N > 1) ? $clog2(N) : 1;
  localparam int FOUR = 4 << FRAC;

  localparam logic [2:0] MAP_S = 3'd0, MAP_F = 3'd1, IT_S = 3'd2,
                         IT_F  = 3'd3, COL_S = 3'd4, COL_F = 3'd5;

  typedef struct packed {
    logic signed [W-1:0] cre, cim, zre, zim, sre, sim;
    logic [NW-1:0]       n;
    logic                esc;
  } dat_t;

  function automatic logic signed [W-1:0] mul(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = a * b;
    p = p >>> FRAC;
    return p[W-1:0];
  endfunction

  function automatic dat_t burst(dat_t d);
    logic signed [W-1:0] nim, nre;
    logic signed [W:0]   s;
    for (int k = 0; k < CHUNK; k++) begin
      if (!d.esc && int'(d.n) < MAX_ITER) begin
        nim   = (mul(d.zre, d.zim) <<< 1) + d.cim;
        nre   = d.sre - d.sim + d.cre;
        d.zim = nim;
        d.zre = nre;
        d.sre = mul(nre, nre);
        d.sim = mul(nim, nim);
        d.n   = d.n + 1'b1;
        s     = (W+1)'(d.sre) + (W+1)'(d.sim);
        d.esc = s > (W+1)'(FOUR);
      end
    end
    return d;
  endfunction

  dat_t          cd  [N];
  logic [2:0]    st  [N];
  logic [CW-1:0] cx  [N];
  logic [CW-1:0] cy  [N];
  logic [NW-1:0] res [N];
  logic [N-1:0]  dn;
  logic [PW-1:0] phase;

  dat_t          pd [LAT];
  logic [LAT-1:0] pv;
  dat_t          fq [N];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  logic fin, stall, take, adv, issue, go, push, last;
  dat_t iss_d, nd;
  logic [2:0] nst;
  logic ndn;
  logic [NW-1:0] nres;

  assign fin   = st[0] == MAP_F || st[0] == IT_F || st[0] == COL_F;
  assign stall = busy && !dn[0] && fin && cnt == '0;
  assign take  = busy && !dn[0] && fin && cnt != '0;
  assign adv   = busy && !stall;
  assign go    = !cd[0].esc && int'(cd[0].n) < MAX_ITER;
  assign issue = busy && !dn[0] && (st[0] == MAP_S || st[0] == COL_S || (st[0] == IT_S && go));
  assign push  = pv[LAT-1];
  assign last  = int'(phase) == N - 1;

  always_comb begin
    iss_d = cd[0];
    if (st[0] == MAP_S) begin
      iss_d     = '0;
      iss_d.cre = W'((int'(cx[0]) - IMG_W / 2) * SCALE);
      iss_d.cim = W'((int'(cy[0]) - IMG_H / 2) * SCALE);
    end else if (st[0] == IT_S) begin
      iss_d = burst(cd[0]);
    end
  end

  always_comb begin
    nd = cd[0]; nst = st[0]; ndn = dn[0]; nres = res[0];
    if (!dn[0]) begin
      case (st[0])
        MAP_S: nst = MAP_F;
        MAP_F: begin
          nd = '0; nd.cre = fq[rp].cre; nd.cim = fq[rp].cim; nst = IT_S;
        end
        IT_S:  nst = go ? IT_F : COL_S;
        IT_F:  begin nd = fq[rp]; nst = IT_S; end
        COL_S: nst = COL_F;
        COL_F: begin nres = fq[rp].n; ndn = 1'b1; nst = MAP_S; end
        default: nst = MAP_S;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < LAT; i++) pd[i] <= '0;
    end else begin
      pv[0] <= issue;
      pd[0] <= iss_d;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      for (int i = 0; i < N; i++) fq[i] <= '0;
    end else begin
      if (push) begin
        fq[wp] <= pd[LAT-1];
        wp <= (int'(wp) == N - 1) ? '0 : wp + 1'b1;
      end
      if (take) rp <= (int'(rp) == N - 1) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; phase <= '0; dn <= '0;
      for (int i = 0; i < N; i++) begin
        cd[i] <= '0; st[i] <= MAP_S; cx[i] <= '0; cy[i] <= '0; res[i] <= '0;
      end
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; done <= 1'b0; phase <= '0; dn <= '0;
        for (int i = 0; i < N; i++) begin
          cd[i] <= '0; st[i] <= MAP_S; res[i] <= '0;
          cx[i] <= px_x[i*CW +: CW];
          cy[i] <= px_y[i*CW +: CW];
        end
      end
    end else if (adv) begin
      for (int i = 0; i < N - 1; i++) begin
        cd[i] <= cd[i+1]; st[i] <= st[i+1]; cx[i] <= cx[i+1];
        cy[i] <= cy[i+1]; res[i] <= res[i+1]; dn[i] <= dn[i+1];
      end
      cd[N-1] <= nd; st[N-1] <= nst; cx[N-1] <= cx[0];
      cy[N-1] <= cy[0]; res[N-1] <= nres; dn[N-1] <= ndn;
      phase <= last ? '0 : phase + 1'b1;
      if (last && ndn && ((dn >> 1) == ({N{1'b1}} >> 1))) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign iters[g*NW +: NW] = res[g];
  end

  assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= N);
  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(cnt) < N || take));
  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st[0] == IT_F) |-> (int'(fq[rp].n) <= int'(cd[0].n) + CHUNK));
  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> int'(fq[rp].n) <= MAX_ITER);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(iters));
endmodule

// File: tb/sim_mandel_ctx_sched.sv
module sim_mandel_ctx_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, LAT = 6, CW = 8, W = 24, FRAC = 12;
  localparam int IMG_W = 64, IMG_H = 64, SCALE = 256, CHUNK = 6, MAX_ITER = 32;
  localparam int NW = $clog2(MAX_ITER + 1);
  localparam int NV = 4;
  localparam int TX [NV][N] = '{'{32, 0, 63}, '{0, 32, 40}, '{20, 28, 36}, '{10, 50, 33}};
  localparam int TY [NV][N] = '{'{32, 0, 63}, '{32, 0, 36}, '{30, 40, 28}, '{10, 20, 33}};

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*CW-1:0] px_x = '0, px_y = '0;
  logic busy, done;
  logic [N*NW-1:0] iters;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mandel_ctx_sched #(.N(N), .LAT(LAT), .CW(CW), .W(W), .FRAC(FRAC), .IMG_W(IMG_W),
    .IMG_H(IMG_H), .SCALE(SCALE), .CHUNK(CHUNK), .MAX_ITER(MAX_ITER)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .px_x(px_x), .px_y(px_y),
    .busy(busy), .done(done), .iters(iters));

  function automatic longint qm(longint a, longint b);
    return (a * b) >>> FRAC;
  endfunction

  function automatic int ref_n(int x, int y);
    longint cre, cim, zre, zim, sre, sim, nre, nim;
    int n;
    bit esc;
    cre = longint'((x - IMG_W/2) * SCALE);
    cim = longint'((y - IMG_H/2) * SCALE);
    zre = 0; zim = 0; sre = 0; sim = 0; n = 0; esc = 0;
    while (!esc && n < MAX_ITER) begin
      nim = 2 * qm(zre, zim) + cim;
      nre = sre - sim + cre;
      zre = nre; zim = nim;
      sre = qm(zre, zre); sim = qm(zim, zim);
      n++;
      esc = (sre + sim) > longint'(4 << FRAC);
    end
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(int v);
    for (int i = 0; i < N; i++) begin
      px_x[i*CW +: CW] = CW'(TX[v][i]);
      px_y[i*CW +: CW] = CW'(TY[v][i]);
    end
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 1;
    while (!done) begin
      @(negedge clk);
      t++;
      if (t > 20000) begin ok = 0; break; end
    end
  endtask

  task automatic check_results(int v, string req);
    for (int i = 0; i < N; i++)
      check(req, int'(iters[i*NW +: NW]), ref_n(TX[v][i], TY[v][i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 iters", int'(iters), 0);

    for (int v = 0; v < NV; v++) begin
      load(v);
      start = 1;
      @(negedge clk);
      start = 0;
      check("R2 busy after start", int'(busy), 1);
      wait_done(ok);
      check("R9 job finished", int'(ok), 1);
      check("R9 busy low at end", int'(busy), 0);
      // R3 R4 R5 R6 R7 R8: counts per pixel in loaded order
      check_results(v, "R8 R4 per-pixel count");
    end

    // R5: c = -2 gives zsq sum exactly 4.0, must not escape -> MAX_ITER
    check("R5 exact 4.0 not escaped", int'(ref_n(0, 32)), MAX_ITER);

    // R2: start while busy is ignored
    load(2);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    load(3);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done(ok);
    check("R2 job finished", int'(ok), 1);
    check_results(2, "R2 busy start ignored");

    // R9: results held while idle
    repeat (20) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check_results(2, "R9 iters held");

    // R6: centre hits the cap in every slot
    for (int i = 0; i < N; i++) begin
      px_x[i*CW +: CW] = 8'd32;
      px_y[i*CW +: CW] = 8'd32;
    end
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done(ok);
    for (int i = 0; i < N; i++)
      check("R6 cap reached", int'(iters[i*NW +: NW]), MAX_ITER);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule